// File: doc/BRIEF.md
# Multiplexed external memory bus controller

This block lets a synchronous on-chip bus master reach an external parallel memory over a small pin budget. The low address byte and the data byte take turns on one shared 8-bit bus, and the high address byte has an 8-bit output of its own. The first cycle of every access carries an address latch strobe, so that an external latch can hold the low address byte before the same wires carry data. Active-low read and write strobes mark the data phase.

The address space has a lower and an upper sector, split at a programmable high-byte boundary. Each sector has its own 2-bit wait code, so a fast and a slow device can share the pins. A bus-keeper option makes the shared bus show its last value while neither side drives it. The model output `bus_level` gives the level seen on the shared wires.

The sequencer states are S_IDLE, S_T1 (address out, latch strobe high), S_T2 (address held), S_T3 (first strobe cycle), S_WAIT (added strobe cycles), S_HOLD (one extra cycle after the strobe for code 11) and S_T4 (completion). The transitions are:
- S_IDLE goes to S_T1 when a request arrives.
- S_T1 goes to S_T2, and S_T2 goes to S_T3.
- S_T3 goes to S_WAIT while wait cycles remain. Otherwise it goes to S_HOLD or S_T4.
- S_WAIT stays until its counter is empty, then goes to S_HOLD or S_T4.
- S_HOLD goes to S_T4.
- S_T4 goes to S_T1 when a new request arrives. Otherwise it goes to S_IDLE.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held, both strobes are high, the latch strobe is low, the shared bus is released (`ext_ad_oe`=0) and `req_ready` is low.
- R2: In the cycle after acceptance (S_T1), `ext_latch`=1, `ext_ad_oe`=1, `ext_ad_o` carries address bits 7:0 and `ext_ahi_o` carries address bits 15:8. In the next cycle (S_T2), `ext_latch`=0 and the low address byte stays driven.
- R3: During every cycle with `ext_wr_n`=0, `ext_ad_oe`=1 and `ext_ad_o` equals the write data, and a later read of the same address returns that data.
- R4: During every cycle with `ext_rd_n`=0, the shared bus is released (`ext_ad_oe`=0). `rsp_rdata` holds the value sampled from `ext_ad_i` in the last read-strobe cycle, and it is valid while `req_ready`=1.
- R5: Wait code 00 gives 1 strobe cycle, 01 gives 2, 10 gives 3, and 11 gives 3 plus one hold cycle. `req_ready` rises in cycle 3+w+h after the acceptance edge, where w is the number of added strobe cycles and h is the hold cycle (0 or 1).
- R6: An access whose address bits 15:8 are at or above `cfg_boundary` uses `cfg_wait_hi`; otherwise it uses `cfg_wait_lo`. Both are sampled when the request is accepted.
- R7: `req_ready` is high for exactly one cycle per access.
- R8: In the completion cycle, `ext_latch` is high exactly when `req_valid` is high (a back-to-back access). That access then starts in S_T1 in the next cycle.
- R9: A `req_valid` pulse outside S_IDLE and S_T4 is ignored: it produces no extra access and no extra completion.
- R10: With `cfg_keep_en`=1, no drive and no read strobe, `bus_level` shows the last value seen on the shared bus (driven or read). With `cfg_keep_en`=0 it follows `ext_ad_i`.
- R11: Between accesses, `ext_ahi_o` and `ext_ad_o` keep the values of the previous access.
- R12: The read and write strobes are never low together, and the latch strobe is never high while either strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request pulse, taken in S_IDLE or S_T4 |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data |
| cfg_boundary | input | 8 | First high byte of the upper sector |
| cfg_wait_lo | input | 2 | Wait code, lower sector |
| cfg_wait_hi | input | 2 | Wait code, upper sector |
| cfg_keep_en | input | 1 | Bus-keeper enable |
| ext_ad_o | output | 8 | Shared bus drive value |
| ext_ad_oe | output | 1 | Shared bus output enable |
| ext_ad_i | input | 8 | Shared bus input from the pads |
| ext_ahi_o | output | 8 | High address byte |
| ext_latch | output | 1 | Address latch strobe, active high |
| ext_rd_n | output | 1 | Read strobe, active low |
| ext_wr_n | output | 1 | Write strobe, active low |
| bus_level | output | 8 | Level seen on the shared bus |

## Verification
The bench places accesses on both sides of the sector boundary, including a high byte equal to it. A design that compares with a strict greater-than would then report the lower sector's latency. It tries all four wait codes, where an off-by-one counter or a missing hold cycle after code 11 shifts the completion cycle and the strobe width. It issues back-to-back requests in the completion cycle, where the latch strobe must fire, and sends a stray request in the middle of an access, which a careless acceptance rule would turn into an extra completion. It also reads the shared bus level during idle with the keeper on and off: a keeper that ignores read data, or that ignores the enable, shows the wrong byte.

// File: rtl/xbus_pkg.sv
package xbus_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_T1,
        S_T2,
        S_T3,
        S_WAIT,
        S_HOLD,
        S_T4
    } xbus_state_t;

    localparam int WCODE_W  = 2;
    localparam int MAX_WAIT = 2;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);

    typedef logic [WCODE_W-1:0] wcode_t;
    typedef logic [CNT_W-1:0]   wcnt_t;

    // added strobe cycles for a wait code
    function automatic wcnt_t wait_cycles(input wcode_t code);
        unique case (code)
            2'b00:   wait_cycles = wcnt_t'(0);
            2'b01:   wait_cycles = wcnt_t'(1);
            default: wait_cycles = wcnt_t'(MAX_WAIT);
        endcase
    endfunction

    // the slowest code adds one cycle after the strobe
    function automatic logic hold_cycle(input wcode_t code);
        hold_cycle = (code == 2'b11);
    endfunction

endpackage

// File: rtl/xbus_sector_sel.sv
module xbus_sector_sel
    import xbus_pkg::*;
#(
    parameter int HI_W = 8
) (
    input  logic [HI_W-1:0] addr_hi,
    input  logic [HI_W-1:0] boundary,
    input  wcode_t          code_lo,
    input  wcode_t          code_hi,
    output wcnt_t           wait_n,
    output logic            hold
);
    wcode_t code_sel;

    always_comb begin
        code_sel = (addr_hi >= boundary) ? code_hi : code_lo;
        wait_n   = wait_cycles(code_sel);
        hold     = hold_cycle(code_sel);
    end
endmodule

// File: rtl/xbus_wait_ctr.sv
module xbus_wait_ctr
    import xbus_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  wcnt_t load_val,
    input  logic  dec,
    output logic  zero
);
    wcnt_t cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_q <= cnt_q - wcnt_t'(1);
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/xbus_keeper.sv
module xbus_keeper #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              keep_en,
    input  logic              drv_oe,
    input  logic [DATA_W-1:0] drv_val,
    input  logic              rd_active,
    input  logic [DATA_W-1:0] pin_in,
    output logic [DATA_W-1:0] last_q,
    output logic [DATA_W-1:0] level
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= '0;
        end else if (drv_oe) begin
            last_q <= drv_val;
        end else if (rd_active) begin
            last_q <= pin_in;
        end
    end

    always_comb begin
        if (drv_oe) begin
            level = drv_val;
        end else if (rd_active || !keep_en) begin
            level = pin_in;
        end else begin
            level = last_q;
        end
    end
endmodule

// File: rtl/xbus_ctrl.sv
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_write,
    output logic                     req_ready,
    output logic [DATA_W-1:0]        rsp_rdata,
    input  logic [ADDR_W-DATA_W-1:0] cfg_boundary,
    input  logic [1:0]               cfg_wait_lo,
    input  logic [1:0]               cfg_wait_hi,
    input  logic                     cfg_keep_en,
    output logic [DATA_W-1:0]        ext_ad_o,
    output logic                     ext_ad_oe,
    input  logic [DATA_W-1:0]        ext_ad_i,
    output logic [ADDR_W-DATA_W-1:0] ext_ahi_o,
    output logic                     ext_latch,
    output logic                     ext_rd_n,
    output logic                     ext_wr_n,
    output logic [DATA_W-1:0]        bus_level
);
    localparam int HI_W = ADDR_W - DATA_W;

    xbus_state_t       state_q, state_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              write_q;
    logic              hold_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] drive_val;
    logic [DATA_W-1:0] keep_last;

    wcnt_t sel_wait;
    logic  sel_hold;
    logic  ctr_zero;
    logic  accept;
    logic  strobe_st;
    logic  last_strobe;

    assign accept      = req_valid && (state_q == S_IDLE || state_q == S_T4);
    assign strobe_st   = (state_q == S_T3) || (state_q == S_WAIT);
    assign last_strobe = strobe_st && ctr_zero;

    xbus_sector_sel #(.HI_W(HI_W)) u_sector (
        .addr_hi  (req_addr[ADDR_W-1:DATA_W]),
        .boundary (cfg_boundary),
        .code_lo  (cfg_wait_lo),
        .code_hi  (cfg_wait_hi),
        .wait_n   (sel_wait),
        .hold     (sel_hold)
    );

    xbus_wait_ctr u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (sel_wait),
        .dec      (strobe_st),
        .zero     (ctr_zero)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (accept) state_d = S_T1;
            S_T1:   state_d = S_T2;
            S_T2:   state_d = S_T3;
            S_T3, S_WAIT: begin
                if (!ctr_zero) begin
                    state_d = S_WAIT;
                end else begin
                    state_d = hold_q ? S_HOLD : S_T4;
                end
            end
            S_HOLD: state_d = S_T4;
            S_T4:   state_d = accept ? S_T1 : S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // request capture and read sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            hold_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                hold_q  <= sel_hold;
            end
            if (last_strobe && !write_q) begin
                rdata_q <= ext_ad_i;
            end
        end
    end

    // outputs
    always_comb begin
        ext_latch = 1'b0;
        ext_ad_oe = 1'b0;
        ext_rd_n  = 1'b1;
        ext_wr_n  = 1'b1;
        req_ready = 1'b0;
        drive_val = addr_q[DATA_W-1:0];
        unique case (state_q)
            S_IDLE: begin
            end
            S_T1: begin
                ext_latch = 1'b1;
                ext_ad_oe = 1'b1;
            end
            S_T2: begin
                ext_ad_oe = 1'b1;
            end
            S_T3, S_WAIT: begin
                if (write_q) begin
                    ext_ad_oe = 1'b1;
                    drive_val = wdata_q;
                    ext_wr_n  = 1'b0;
                end else begin
                    ext_rd_n  = 1'b0;
                end
            end
            S_HOLD: begin
                if (write_q) begin
                    ext_ad_oe = 1'b1;
                    drive_val = wdata_q;
                end
            end
            S_T4: begin
                req_ready = 1'b1;
                ext_latch = req_valid;
            end
            default: begin
            end
        endcase
    end

    xbus_keeper #(.DATA_W(DATA_W)) u_keep (
        .clk       (clk),
        .rst_n     (rst_n),
        .keep_en   (cfg_keep_en),
        .drv_oe    (ext_ad_oe),
        .drv_val   (drive_val),
        .rd_active (!ext_rd_n),
        .pin_in    (ext_ad_i),
        .last_q    (keep_last),
        .level     (bus_level)
    );

    assign ext_ad_o  = ext_ad_oe ? drive_val : keep_last;
    assign ext_ahi_o = addr_q[ADDR_W-1:DATA_W];
    assign rsp_rdata = rdata_q;
endmodule

// File: rtl/xbus_ctrl_chk.sv
module xbus_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int HI_W   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              cfg_keep_en,
    input logic [DATA_W-1:0] ext_ad_o,
    input logic              ext_ad_oe,
    input logic [HI_W-1:0]   ext_ahi_o,
    input logic              ext_latch,
    input logic              ext_rd_n,
    input logic              ext_wr_n,
    input logic [DATA_W-1:0] bus_level
);
    // R12
    a_r12_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ext_rd_n && !ext_wr_n));

    // R12
    a_r12_latch_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ext_latch |-> (ext_rd_n && ext_wr_n));

    // R4
    a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_rd_n |-> !ext_ad_oe);

    // R7
    a_r7_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);

    // R3
    a_r3_wdata_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_wr_n && !$past(ext_wr_n)) |-> $stable(ext_ad_o));

    // R11
    a_r11_hi_stable_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!ext_rd_n || !ext_wr_n) |-> $stable(ext_ahi_o));

    // R10
    a_r10_keeper_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_keep_en && $stable(cfg_keep_en) && !ext_ad_oe && ext_rd_n
         && !$past(ext_ad_oe) && $past(ext_rd_n)) |-> $stable(bus_level));
endmodule

bind xbus_ctrl xbus_ctrl_chk #(.DATA_W(DATA_W), .HI_W(ADDR_W - DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .cfg_keep_en (cfg_keep_en),
    .ext_ad_o    (ext_ad_o),
    .ext_ad_oe   (ext_ad_oe),
    .ext_ahi_o   (ext_ahi_o),
    .ext_latch   (ext_latch),
    .ext_rd_n    (ext_rd_n),
    .ext_wr_n    (ext_wr_n),
    .bus_level   (bus_level)
);

// File: tb/xbus_ctrl_bench.sv
module xbus_ctrl_bench;
    localparam logic [7:0] FLOAT_VAL = 8'hA5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_ready;
    logic [7:0]  rsp_rdata;
    logic [7:0]  cfg_boundary = 8'h80;
    logic [1:0]  cfg_wait_lo = 2'b00;
    logic [1:0]  cfg_wait_hi = 2'b11;
    logic        cfg_keep_en = 1'b1;
    logic [7:0]  ext_ad_o;
    logic        ext_ad_oe;
    logic [7:0]  ext_ad_i;
    logic [7:0]  ext_ahi_o;
    logic        ext_latch;
    logic        ext_rd_n;
    logic        ext_wr_n;
    logic [7:0]  bus_level;

    always #5 clk = ~clk;

    xbus_ctrl u_xbus_ctrl (.*);

    typedef struct {
        bit          wr;
        logic [15:0] addr;
        logic [7:0]  data;
        int          lat;
        int          strobe;
        int          acc;
    } item_t;

    item_t       q[$];
    int          pending = 0;
    int          cyc = 0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;
    logic [7:0]  mem[0:255];
    logic [7:0]  exp_mem[0:255];
    logic [7:0]  lat_lo = '0;
    logic [7:0]  last_bus = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // external memory: latches the low byte on the latch strobe
    always @(negedge clk) begin
        if (ext_latch && ext_ad_oe) lat_lo <= ext_ad_o;
        if (!ext_wr_n) mem[lat_lo] <= ext_ad_o;
    end
    always_comb ext_ad_i = !ext_rd_n ? mem[lat_lo] : FLOAT_VAL;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // driver: pushes the expected result, then pulses the request
    task automatic issue(input logic [15:0] addr, input logic [7:0] data,
                         input bit wr, input bit b2b);
        item_t  it;
        logic [1:0] code;
        int     w;
        int     h;
        if (b2b) begin
            do @(negedge clk); while (!req_ready);
        end else begin
            do @(negedge clk); while (!(pending == 0 && !req_ready));
        end
        code = (addr[15:8] >= cfg_boundary) ? cfg_wait_hi : cfg_wait_lo;
        w = (code == 2'b00) ? 0 : (code == 2'b01) ? 1 : 2;
        h = (code == 2'b11) ? 1 : 0;
        it.wr = wr;
        it.addr = addr;
        if (wr) begin
            exp_mem[addr[7:0]] = data;
            it.data = data;
        end else begin
            it.data = exp_mem[addr[7:0]];
        end
        it.lat = 3 + w + h;
        it.strobe = 1 + w;
        it.acc = cyc + 1;
        if (!wr) last_bus = it.data;
        else last_bus = data;
        q.push_back(it);
        pending++;
        req_addr = addr;
        req_wdata = data;
        req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (!(pending == 0 && !req_ready));
        #2;
    endtask

    // monitor: pops expected items at each completion
    initial begin
        item_t      it;
        int         strobe_run = 0;
        bit         t1_prev = 1'b0;
        bit         ready_prev = 1'b0;
        logic [7:0] t1_lo = '0;
        forever begin
            @(negedge clk);
            #2;
            if (!rst_n) continue;
            if (!ext_rd_n && !ext_wr_n) chk("R12 both strobes low", 1, 0);
            if (ext_latch && (!ext_rd_n || !ext_wr_n)) chk("R12 latch during strobe", 1, 0);
            if (ready_prev) chk("R7 ready longer than one cycle", req_ready, 0);
            if (t1_prev) begin
                chk("R2 latch low in T2", ext_latch, 0);
                chk("R2 oe held in T2", ext_ad_oe, 1);
                chk("R2 low byte held in T2", ext_ad_o, t1_lo);
            end
            t1_prev = 1'b0;
            if (ext_latch && ext_ad_oe && q.size() > 0) begin
                chk("R2 high byte in T1", ext_ahi_o, q[0].addr[15:8]);
                chk("R2 low byte in T1", ext_ad_o, q[0].addr[7:0]);
                t1_prev = 1'b1;
                t1_lo = q[0].addr[7:0];
            end
            if (!ext_wr_n && q.size() > 0) begin
                chk("R3 write drive", ext_ad_oe, 1);
                chk("R3 write data", ext_ad_o, q[0].data);
            end
            if (!ext_rd_n) chk("R4 bus released on read", ext_ad_oe, 0);
            if (!ext_rd_n || !ext_wr_n) strobe_run++;
            if (req_ready) begin
                chk("R8 latch in completion cycle", ext_latch, req_valid);
                if (q.size() == 0) begin
                    chk("R9 unexpected completion", 1, 0);
                end else begin
                    it = q.pop_front();
                    chk("R5 R6 completion cycle", cyc - it.acc, it.lat);
                    chk("R5 strobe width", strobe_run, it.strobe);
                    if (!it.wr) chk("R4 read data", rsp_rdata, it.data);
                    pending--;
                end
                strobe_run = 0;
            end
            ready_prev = req_ready;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired act=1 exp=0");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i * 7 + 3);
            exp_mem[i] = 8'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        chk("R1 rd strobe in reset", ext_rd_n, 1);
        chk("R1 wr strobe in reset", ext_wr_n, 1);
        chk("R1 latch in reset", ext_latch, 0);
        chk("R1 oe in reset", ext_ad_oe, 0);
        chk("R1 ready in reset", req_ready, 0);
        rst_n = 1'b1;

        // lower sector, code 00
        issue(16'h1010, 8'h5A, 1'b1, 1'b0);
        issue(16'h1010, 8'h00, 1'b0, 1'b0);
        // upper sector, code 11
        issue(16'h9020, 8'hC3, 1'b1, 1'b0);
        wait_idle();
        chk("R10 keeper shows last write", bus_level, 8'hC3);
        chk("R11 low byte kept", ext_ad_o, 8'hC3);
        chk("R11 high byte kept", ext_ahi_o, 8'h90);
        cfg_keep_en = 1'b0;
        #1;
        chk("R10 keeper off follows pins", bus_level, FLOAT_VAL);
        cfg_keep_en = 1'b1;

        // back-to-back pair (R8)
        issue(16'h9020, 8'h00, 1'b0, 1'b0);
        issue(16'h1010, 8'h00, 1'b0, 1'b1);
        // boundary edge (R6)
        issue(16'h8030, 8'h00, 1'b0, 1'b0);
        issue(16'h7F40, 8'h00, 1'b0, 1'b0);

        // codes 01 and 10
        wait_idle();
        cfg_wait_lo = 2'b01;
        cfg_wait_hi = 2'b10;
        issue(16'h2050, 8'h00, 1'b0, 1'b0);
        issue(16'hF060, 8'h3C, 1'b1, 1'b0);
        issue(16'hF060, 8'h00, 1'b0, 1'b1);
        issue(16'h8070, 8'h96, 1'b1, 1'b1);

        // stray request mid-access (R9)
        issue(16'h9080, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        req_addr = 16'h0011;
        req_write = 1'b1;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait_idle();
        for (int k = 0; k < 6; k++) begin
            chk("R9 no access after stray request", {ext_latch, ext_rd_n, ext_wr_n, req_ready}, 4'b0110);
            @(negedge clk);
            #2;
        end
        chk("R9 stray write left memory alone", mem[8'h11], exp_mem[8'h11]);
        chk("R10 keeper shows last read", bus_level, last_bus);
        chk("R11 high byte kept after read", ext_ahi_o, 8'h90);

        done = 1'b1;
        summary();
    end
endmodule